// File: doc/BRIEF.md
# Remappable Peripheral Pin Crossbar

This block routes signals between a set of on-chip peripherals and a fixed group of up to sixteen general-purpose pins. Each peripheral input has its own select register. The value written there names the pin that feeds that input. The routed value is registered, so a pin reaches its peripheral one clock later. Each pin has its own output-function register that picks what drives the pad: a peripheral output, or the pin's general-purpose output latch.

Input routing and output routing are held in two independent register sets. One peripheral can therefore take its input from one pin and drive its output on any other pin. Per-pin direction bits alone decide whether a pad is driven. Input routing never changes a pin's driver.

Software configures the block through a plain register write/read port. After configuration, a lock can be closed. While the lock is closed, mapping writes are dropped. Reopening the lock needs a two-word key sequence written on back-to-back cycles.

Top module: `pin_route_xbar`

## Requirements
- R1: After reset every input-select and output-function register reads 0, the lock reads open (address 0x22, bit 0 = 0), every direction bit is 1 (input) so padOe is all zero, padOut is zero, and one cycle after reset every peripheral input follows pin 0.
- R2: Writing n (0 to NUM_PINS-1) to the input-select register of peripheral input i (address i) makes periphIn[i] equal pinIn[n] as sampled at the next rising clock edge.
- R3: An input-select value of NUM_PINS or above (16 to 31 by default) drives periphIn[i] to its idle level, which is 1 by default, whatever the pins carry.
- R4: For pin j, the output-function register at address 0x10+j decodes as follows. Code 0 drives padOut[j] from bit j of the output latch (address 0x21). Code k in 1..NUM_POUT drives it from periphOut[k-1]. A code above NUM_POUT drives 0.
- R5: padOe[j] is the inverse of direction bit j (address 0x21 is the latch, address 0x20 is direction, 1 = input). padOut[j] is 0 while pin j is an input. Input-select writes never change padOe.
- R6: While the lock is closed, writes to input-select and output-function registers are ignored. Direction and latch writes still take effect.
- R7: The lock opens only when KEY_A (0x00A5) is written to address 0x22 and KEY_B (0x005A) is written there on the very next cycle. Any idle cycle or other write between the two aborts the sequence.
- R8: Writing CLOSE_CODE (0x00C3) to address 0x22 closes the lock from the next cycle on.
- R9: Every mapping, direction and latch register reads back its stored value on regRdata in the same cycle its address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 6 | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for regAddr |
| pinIn | input | NUM_PINS | Values seen on the pads |
| padOut | output | NUM_PINS | Value driven to each pad |
| padOe | output | NUM_PINS | Pad driver enable, 1 = drive |
| periphOut | input | NUM_POUT | Outputs of the peripherals |
| periphIn | output | NUM_IN | Routed inputs to the peripherals |

## Verification
A wrong input-select register shows up at the ports one clock edge after the pins change: periphIn carries the wrong pin, or it fails to hold its idle level for an out-of-range code. A corrupted output-function or direction register shows on padOut or padOe in the same cycle, with no register in that path. A lock state machine that arms too eagerly, or misses an abort, only becomes visible on the next mapping write. For that reason the bench follows every key sequence with a mapping write and a readback of the lock and of the mapping.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int SEL_W  = 5;
  localparam int IDX_W  = 4;

  localparam logic [ADDR_W-1:0] ADDR_OUTFN_BASE = 6'h10;
  localparam logic [ADDR_W-1:0] ADDR_DIR        = 6'h20;
  localparam logic [ADDR_W-1:0] ADDR_LAT        = 6'h21;
  localparam logic [ADDR_W-1:0] ADDR_LOCK       = 6'h22;

  localparam logic [DATA_W-1:0] KEY_A      = 16'h00A5;
  localparam logic [DATA_W-1:0] KEY_B      = 16'h005A;
  localparam logic [DATA_W-1:0] CLOSE_CODE = 16'h00C3;

  typedef struct packed {
    logic              wrInSel;
    logic              wrOutFn;
    logic              wrDir;
    logic              wrLat;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } cfgStrobe_t;
endpackage

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int NUM_IN   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output cfgStrobe_t        strb,
  output logic              lockedQ
);
  localparam logic [ADDR_W-1:0] IN_END  = ADDR_W'(NUM_IN);
  localparam logic [ADDR_W-1:0] OUT_END = ADDR_OUTFN_BASE + ADDR_W'(NUM_PINS);

  logic armedQ;
  logic keyHit;
  logic inRange;
  logic outRange;

  assign keyHit   = regWe && (regAddr == ADDR_LOCK);
  assign inRange  = regAddr < IN_END;
  assign outRange = (regAddr >= ADDR_OUTFN_BASE) && (regAddr < OUT_END);

  always_comb begin
    strb.wrInSel = regWe && !lockedQ && inRange;
    strb.wrOutFn = regWe && !lockedQ && outRange;
    strb.wrDir   = regWe && (regAddr == ADDR_DIR);
    strb.wrLat   = regWe && (regAddr == ADDR_LAT);
    strb.idx     = regAddr[IDX_W-1:0];
    strb.data    = regWdata;
  end

  // Two-word unlock: the first key arms for exactly one cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockedQ <= 1'b0;
      armedQ  <= 1'b0;
    end else begin
      armedQ <= keyHit && (regWdata == KEY_A);
      if (keyHit && (regWdata == CLOSE_CODE))
        lockedQ <= 1'b1;
      else if (keyHit && armedQ && (regWdata == KEY_B))
        lockedQ <= 1'b0;
    end
  end
endmodule

// File: rtl/xbar_datapath.sv
module xbar_datapath
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int NUM_IN   = 4,
  parameter int NUM_POUT = 6,
  parameter logic [NUM_IN-1:0] IDLE_LEVEL = '1,
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int MAP_W = (NUM_IN + NUM_PINS) * SEL_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  cfgStrobe_t          strb,
  input  logic                lockedQ,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   rdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  input  logic [NUM_POUT-1:0] periphOut,
  output logic [NUM_IN-1:0]   periphIn,
  output logic [MAP_W-1:0]    mapFlat
);
  logic [SEL_W-1:0]    inSel [NUM_IN];
  logic [SEL_W-1:0]    outFn [NUM_PINS];
  logic [NUM_PINS-1:0] dirQ;
  logic [NUM_PINS-1:0] latQ;
  logic [31:0]         pOutExt;

  assign pOutExt = 32'(periphOut);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ <= '1;
      latQ <= '0;
    end else begin
      if (strb.wrDir) dirQ <= strb.data[NUM_PINS-1:0];
      if (strb.wrLat) latQ <= strb.data[NUM_PINS-1:0];
    end
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : gIn
    logic rawIn;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        inSel[i]    <= '0;
        periphIn[i] <= IDLE_LEVEL[i];
      end else begin
        if (strb.wrInSel && (strb.idx == IDX_W'(i)))
          inSel[i] <= strb.data[SEL_W-1:0];
        periphIn[i] <= rawIn;
      end
    end
    always_comb begin
      if (32'(inSel[i]) < NUM_PINS) rawIn = pinIn[inSel[i][PIN_W-1:0]];
      else                          rawIn = IDLE_LEVEL[i];
    end
    assign mapFlat[i*SEL_W +: SEL_W] = inSel[i];
  end

  for (genvar j = 0; j < NUM_PINS; j++) begin : gPin
    logic srcBit;
    always_ff @(posedge clk) begin
      if (!rstN)
        outFn[j] <= '0;
      else if (strb.wrOutFn && (strb.idx == IDX_W'(j)))
        outFn[j] <= strb.data[SEL_W-1:0];
    end
    // Codes past the peripheral count land on the zero-extended part.
    always_comb begin
      if (outFn[j] == '0) srcBit = latQ[j];
      else                srcBit = pOutExt[SEL_W'(outFn[j] - SEL_W'(1))];
    end
    assign padOe[j]  = ~dirQ[j];
    assign padOut[j] = srcBit & ~dirQ[j];
    assign mapFlat[(NUM_IN + j)*SEL_W +: SEL_W] = outFn[j];
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_IN; i++)
      if (rdAddr == ADDR_W'(i)) rdData = DATA_W'(inSel[i]);
    for (int j = 0; j < NUM_PINS; j++)
      if (rdAddr == ADDR_OUTFN_BASE + ADDR_W'(j)) rdData = DATA_W'(outFn[j]);
    if (rdAddr == ADDR_DIR)  rdData = DATA_W'(dirQ);
    if (rdAddr == ADDR_LAT)  rdData = DATA_W'(latQ);
    if (rdAddr == ADDR_LOCK) rdData = DATA_W'(lockedQ);
  end
endmodule

// File: rtl/pin_route_xbar.sv
module pin_route_xbar
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int NUM_IN   = 4,
  parameter int NUM_POUT = 6,
  parameter logic [NUM_IN-1:0] IDLE_LEVEL = '1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  input  logic [NUM_POUT-1:0] periphOut,
  output logic [NUM_IN-1:0]   periphIn
);
  localparam int MAP_W = (NUM_IN + NUM_PINS) * SEL_W;

  cfgStrobe_t       strb;
  logic             lockedQ;
  logic [MAP_W-1:0] mapFlat;

  xbar_ctrl #(.NUM_PINS(NUM_PINS), .NUM_IN(NUM_IN)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .strb(strb), .lockedQ(lockedQ)
  );

  xbar_datapath #(
    .NUM_PINS(NUM_PINS), .NUM_IN(NUM_IN), .NUM_POUT(NUM_POUT),
    .IDLE_LEVEL(IDLE_LEVEL)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .lockedQ(lockedQ),
    .rdAddr(regAddr), .rdData(regRdata), .pinIn(pinIn),
    .padOut(padOut), .padOe(padOe), .periphOut(periphOut),
    .periphIn(periphIn), .mapFlat(mapFlat)
  );
endmodule

// File: rtl/pin_route_xbar_chk.sv
module pin_route_xbar_chk
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int MAP_W    = 100
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWe,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [DATA_W-1:0]   regWdata,
  input logic [NUM_PINS-1:0] padOe,
  input logic                lockedQ,
  input logic [MAP_W-1:0]    mapFlat
);
  AST_LOCKED_MAP_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    lockedQ |=> $stable(mapFlat)); // R6

  AST_UNLOCK_NEEDS_KEY_B: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockedQ) |-> $past(regWe && regAddr == ADDR_LOCK && regWdata == KEY_B)); // R7

  AST_UNLOCK_NEEDS_KEY_A: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockedQ) |-> $past(regWe && regAddr == ADDR_LOCK && regWdata == KEY_A, 2)); // R7

  AST_CLOSE_TAKES_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_LOCK && regWdata == CLOSE_CODE) |=> lockedQ); // R8

  AST_OE_ONLY_BY_DIR: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(padOe) |-> $past(regWe && regAddr == ADDR_DIR)); // R5
endmodule

bind pin_route_xbar pin_route_xbar_chk #(.NUM_PINS(NUM_PINS), .MAP_W(MAP_W)) uChk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .padOe(padOe), .lockedQ(lockedQ), .mapFlat(mapFlat)
);

// File: tb/sim_pin_route_xbar.sv
module sim_pin_route_xbar;
  import xbar_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;
  localparam int NI = 4;
  localparam int NO = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWe = 1'b0;
  logic [5:0]    regAddr = '0;
  logic [15:0]   regWdata = '0;
  logic [15:0]   regRdata;
  logic [NP-1:0] pinIn = '0;
  logic [NP-1:0] padOut;
  logic [NP-1:0] padOe;
  logic [NO-1:0] periphOut = '0;
  logic [NI-1:0] periphIn;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_route_xbar u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pinIn(pinIn),
    .padOut(padOut), .padOe(padOe), .periphOut(periphOut),
    .periphIn(periphIn)
  );

  // {select, pin pattern, expected periphIn[0]}
  localparam logic [21:0] VEC [7] = '{
    {5'd0,  16'h0001, 1'b1},
    {5'd5,  16'h0020, 1'b1},
    {5'd5,  16'hFFDF, 1'b0},
    {5'd15, 16'h8000, 1'b1},
    {5'd15, 16'h7FFF, 1'b0},
    {5'd16, 16'h0000, 1'b1},
    {5'd31, 16'h0000, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic putWrite(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
  endtask

  task automatic endWrite();
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    putWrite(a, d);
    endWrite();
  endtask

  task automatic rd(input logic [5:0] a, input string tag, input logic [15:0] exp);
    @(negedge clk);
    regWe = 1'b0; regAddr = a;
    #1;
    chk(tag, 32'(regRdata), 32'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 padOe", 32'(padOe), 32'h0);
    chk("R1 padOut", 32'(padOut), 32'h0);
    chk("R1 periphIn", 32'(periphIn), 32'h0);
    rd(6'h00, "R1 inSel0", 16'h0);
    rd(6'h13, "R1 outFn3", 16'h0);
    rd(6'h22, "R1 lock open", 16'h0);
    rd(6'h20, "R1 dir", 16'hFFFF);

    // R2 R3 routing table
    for (int k = 0; k < 7; k++) begin
      pinIn = VEC[k][16:1];
      wr(6'h00, 16'(VEC[k][21:17]));
      @(negedge clk);
      chk($sformatf("R2/R3 vec%0d", k), 32'(periphIn[0]), 32'(VEC[k][0]));
    end
    rd(6'h00, "R9 inSel0", 16'd31);

    // R4 output decode
    wr(6'h20, 16'h0000);
    wr(6'h21, 16'hA5A5);
    @(negedge clk);
    chk("R4 latch code0", 32'(padOut), 32'hA5A5);
    wr(6'h13, 16'd2);
    periphOut = 6'b000010;
    #1 chk("R4 code2 high", 32'(padOut), 32'hA5AD);
    periphOut = 6'b111101;
    #1 chk("R4 code2 low", 32'(padOut), 32'hA5A5);
    wr(6'h13, 16'd7);
    periphOut = 6'b111111;
    #1 chk("R4 code over range", 32'(padOut), 32'hA5A5);
    wr(6'h13, 16'd6);
    periphOut = 6'b100000;
    #1 chk("R4 code6", 32'(padOut), 32'hA5AD);

    // R5 direction
    wr(6'h20, 16'hFF00);
    @(negedge clk);
    chk("R5 padOe", 32'(padOe), 32'h00FF);
    chk("R5 padOut gated", 32'(padOut), 32'h00AD);
    pinIn = 16'h0004;
    wr(6'h01, 16'd2);
    @(negedge clk);
    chk("R5 oe after input map", 32'(padOe), 32'h00FF);
    chk("R2 reads output pin", 32'(periphIn[1]), 32'h1);

    // R8 R6 lock
    wr(6'h22, CLOSE_CODE);
    rd(6'h22, "R8 locked", 16'h1);
    wr(6'h13, 16'd0);
    rd(6'h13, "R6 outFn kept", 16'd6);
    chk("R6 padOut kept", 32'(padOut), 32'h00AD);
    wr(6'h01, 16'd9);
    rd(6'h01, "R6 inSel kept", 16'd2);
    wr(6'h20, 16'hFFFF);
    @(negedge clk);
    chk("R6 dir still writable", 32'(padOe), 32'h0);

    // R7 unlock sequences
    wr(6'h22, KEY_A);
    wr(6'h22, KEY_B);
    rd(6'h22, "R7 idle aborts", 16'h1);
    putWrite(6'h22, KEY_A);
    putWrite(6'h21, 16'h0000);
    putWrite(6'h22, KEY_B);
    endWrite();
    rd(6'h22, "R7 other write aborts", 16'h1);
    putWrite(6'h22, KEY_A);
    putWrite(6'h22, KEY_B);
    endWrite();
    rd(6'h22, "R7 unlocked", 16'h0);
    wr(6'h13, 16'd0);
    rd(6'h13, "R7 write after unlock", 16'd0);
    rd(6'h21, "R9 latch", 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule